// File: doc/BRIEF.md
# Knockout Switch Output Port Interface

This block sits at one output of a knockout-style packet switch. In every slot (one clock cycle) each of the `NUM_IN` inputs may broadcast one packet, made of a destination address and a data word, and every output port sees all of them. The interface keeps only the packets whose destination equals its own `PORT_ID`. From those matches a concentrator keeps at most `NUM_LANE` per slot and discards the rest. The kept packets are spread over `NUM_LANE` small FIFO lanes, which together behave as one shared queue. A reader takes at most one packet per cycle from them and presents it at the output.

Packets are placed into lanes by a rotating write pointer, and the reader follows the same rotation, so packets leave in the order they were kept. The concentrator starts its scan of the inputs at a rotating offset, so that in overload the losses fall on different inputs from slot to slot. Every discarded packet adds one to a saturating loss counter. This covers both packets beyond the per-slot limit and packets that find their lane full.

Top module: `koq_output_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `loss_count` is 0.
- R2: Input i is a match only when `in_valid[i]` is 1 and `in_dest[i*ADDR_W +: ADDR_W]` equals `PORT_ID`. All other packets produce no output and do not change `loss_count`.
- R3: In one cycle at most `NUM_LANE` matches are kept. Each match that is not kept adds one to `loss_count`.
- R4: Matches are scanned in input index order starting at a scan offset and wrapping past `NUM_IN-1` to 0. The first `NUM_LANE` matches in scan order are kept. The offset is 0 in the first cycle after reset and advances by 1 modulo `NUM_IN` every cycle.
- R5: Packets leave in the order they were kept. Packets kept in the same cycle leave in scan order.
- R6: At most one packet leaves per cycle. A packet kept at clock edge t shows on `out_data` with `out_valid` high after edge t+1 at the earliest, and exactly then if the buffer was empty before edge t.
- R7: The kept packet of rank k in a cycle goes to lane (write pointer + k) mod `NUM_LANE`, and the write pointer then advances by the number written. Lane fullness is judged on the state before the edge. A packet whose lane is full is dropped, together with all lower-ranked packets of that cycle, and each drop counts in `loss_count`. The buffer therefore holds at most `NUM_LANE*LANE_DEPTH` packets.
- R8: `loss_count` saturates at all ones and stays there.
- R9: `out_valid` is high after an edge exactly when the buffer held at least one packet before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_IN | Per-input packet present this slot |
| in_dest | input | NUM_IN*ADDR_W | Per-input destination; input i at bits [i*ADDR_W +: ADDR_W] |
| in_data | input | NUM_IN*DATA_W | Per-input data; input i at bits [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | A packet is presented on out_data |
| out_data | output | DATA_W | Packet leaving toward the output port |
| loss_count | output | LOSS_W | Saturating count of discarded matching packets |

## Verification
Two kinds of loss can happen in the same cycle: the concentrator drops matches beyond the lane count, and the write stage drops kept packets that find their lane full. Both are provoked by holding every input on this port's address for many cycles while the reader drains only one packet per cycle, so the shared buffer fills while the concentrator is still overloaded. A behavioural queue of fixed total capacity predicts, every cycle, the popped packet and the combined loss. The loss rise over the burst is also checked against what concentrator drops alone could explain.

// File: rtl/koq_pkg.sv
package koq_pkg;

  // (a + b) mod m, used for every rotating pointer and scan position
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned m);
    return (a + b) % m;
  endfunction

  // (a - b) mod m, distance of a ahead of b on a ring of size m
  function automatic int unsigned wrap_sub(int unsigned a, int unsigned b, int unsigned m);
    return (a + m - (b % m)) % m;
  endfunction

  // bit width able to index n items (at least one bit)
  function automatic int unsigned idx_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/koq_addr_filter.sv
module koq_addr_filter #(
  parameter int NUM_IN  = 8,
  parameter int ADDR_W  = 3,
  parameter int PORT_ID = 3
) (
  input  logic [NUM_IN-1:0]        in_valid,
  input  logic [NUM_IN*ADDR_W-1:0] in_dest,
  output logic [NUM_IN-1:0]        hit
);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IN; gi++) begin : g_cmp
      assign hit[gi] = in_valid[gi] && (in_dest[gi*ADDR_W +: ADDR_W] == ADDR_W'(PORT_ID));
    end
  endgenerate

endmodule

// File: rtl/koq_concentrator.sv
module koq_concentrator
  import koq_pkg::*;
#(
  parameter int NUM_IN   = 8,
  parameter int NUM_LANE = 4,
  parameter int IN_W     = 3,
  parameter int CNT_W    = 4
) (
  input  logic [NUM_IN-1:0]              hit,
  input  logic [IN_W-1:0]                scan_base,
  output logic [NUM_LANE-1:0]            pick_ok,
  output logic [NUM_LANE-1:0][IN_W-1:0]  pick_src,
  output logic [CNT_W-1:0]               hit_cnt
);

  // Walk the inputs from the rotating base; the first NUM_LANE hits win.
  always_comb begin
    int unsigned taken;
    int unsigned src;
    pick_ok  = '0;
    pick_src = '0;
    hit_cnt  = '0;
    taken    = 0;
    src      = 0;
    for (int j = 0; j < NUM_IN; j++) begin
      src = wrap_add(int'(scan_base), j, NUM_IN);
      if (hit[src]) begin
        hit_cnt = hit_cnt + CNT_W'(1);
        if (taken < NUM_LANE) begin
          pick_ok[taken]  = 1'b1;
          pick_src[taken] = IN_W'(src);
          taken           = taken + 1;
        end
      end
    end
  end

endmodule

// File: rtl/koq_lane_fifo.sv
module koq_lane_fifo
  import koq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty
);

  localparam int PTR_W = idx_bits(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [OCC_W-1:0]  occ;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return PTR_W'(wrap_add(int'(p), 1, DEPTH));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end

  assign rdata = store[rp];
  assign full  = (occ == OCC_W'(DEPTH));
  assign empty = (occ == '0);

  // R7: the write stage never pushes into a full lane
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R6: the reader never pops an empty lane
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/koq_output_port.sv
module koq_output_port
  import koq_pkg::*;
#(
  parameter int NUM_IN     = 8,
  parameter int NUM_LANE   = 4,
  parameter int LANE_DEPTH = 8,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16,
  parameter int LOSS_W     = 16,
  parameter int PORT_ID    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IN-1:0]          in_valid,
  input  logic [NUM_IN*ADDR_W-1:0]   in_dest,
  input  logic [NUM_IN*DATA_W-1:0]   in_data,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          out_data,
  output logic [LOSS_W-1:0]          loss_count
);

  localparam int IN_W   = idx_bits(NUM_IN);
  localparam int LANE_W = idx_bits(NUM_LANE);
  localparam int CNT_W  = $clog2(NUM_IN + 1);
  localparam int SUM_W  = LOSS_W + 1;

  // named internal events
  logic [NUM_IN-1:0]             hit;
  logic [NUM_LANE-1:0]           pick_ok;
  logic [NUM_LANE-1:0][IN_W-1:0] pick_src;
  logic [CNT_W-1:0]              hit_cnt;
  logic [NUM_LANE-1:0]           acc_ok;
  logic [CNT_W-1:0]              acc_cnt;
  logic [CNT_W-1:0]              drop_cnt;
  logic [NUM_LANE-1:0]           lane_push, lane_pop, lane_full, lane_empty;
  logic [DATA_W-1:0]             lane_wdata [NUM_LANE];
  logic [DATA_W-1:0]             lane_rdata [NUM_LANE];
  logic                          read_any;
  logic                          stored_any;
  logic [SUM_W-1:0]              loss_sum;

  logic [IN_W-1:0]   scan_base;
  logic [LANE_W-1:0] wr_lane, rd_lane;

  koq_addr_filter #(
    .NUM_IN (NUM_IN),
    .ADDR_W (ADDR_W),
    .PORT_ID(PORT_ID)
  ) u_filter (
    .in_valid(in_valid),
    .in_dest (in_dest),
    .hit     (hit)
  );

  koq_concentrator #(
    .NUM_IN  (NUM_IN),
    .NUM_LANE(NUM_LANE),
    .IN_W    (IN_W),
    .CNT_W   (CNT_W)
  ) u_conc (
    .hit      (hit),
    .scan_base(scan_base),
    .pick_ok  (pick_ok),
    .pick_src (pick_src),
    .hit_cnt  (hit_cnt)
  );

  // Write stage: ranks go to consecutive lanes from wr_lane; stop at first full lane.
  always_comb begin
    logic run;
    run     = 1'b1;
    acc_ok  = '0;
    acc_cnt = '0;
    for (int k = 0; k < NUM_LANE; k++) begin
      if (run && pick_ok[k] && !lane_full[wrap_add(int'(wr_lane), k, NUM_LANE)]) begin
        acc_ok[k] = 1'b1;
        acc_cnt   = acc_cnt + CNT_W'(1);
      end else begin
        run = 1'b0;
      end
    end
  end

  assign drop_cnt = hit_cnt - acc_cnt;

  always_comb begin
    for (int m = 0; m < NUM_LANE; m++) begin
      int unsigned rank;
      rank          = wrap_sub(m, int'(wr_lane), NUM_LANE);
      lane_push[m]  = acc_ok[rank];
      lane_wdata[m] = in_data[int'(pick_src[rank])*DATA_W +: DATA_W];
    end
  end

  // Read stage: follow the same rotation as the writes.
  assign read_any   = !lane_empty[rd_lane];
  assign stored_any = !(&lane_empty);

  always_comb begin
    lane_pop = '0;
    lane_pop[rd_lane] = read_any;
  end

  genvar gl;
  generate
    for (gl = 0; gl < NUM_LANE; gl++) begin : g_lane
      koq_lane_fifo #(
        .DATA_W(DATA_W),
        .DEPTH (LANE_DEPTH)
      ) u_lane (
        .clk  (clk),
        .rst_n(rst_n),
        .push (lane_push[gl]),
        .wdata(lane_wdata[gl]),
        .pop  (lane_pop[gl]),
        .rdata(lane_rdata[gl]),
        .full (lane_full[gl]),
        .empty(lane_empty[gl])
      );
    end
  endgenerate

  assign loss_sum = {1'b0, loss_count} + SUM_W'(drop_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_base  <= '0;
      wr_lane    <= '0;
      rd_lane    <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      loss_count <= '0;
    end else begin
      scan_base <= IN_W'(wrap_add(int'(scan_base), 1, NUM_IN));
      wr_lane   <= LANE_W'(wrap_add(int'(wr_lane), int'(acc_cnt), NUM_LANE));
      if (read_any) begin
        rd_lane  <= LANE_W'(wrap_add(int'(rd_lane), 1, NUM_LANE));
        out_data <= lane_rdata[rd_lane];
      end
      out_valid  <= read_any;
      loss_count <= loss_sum[LOSS_W] ? {LOSS_W{1'b1}} : loss_sum[LOSS_W-1:0];
    end
  end

  // R2: every concentrator pick is a packet the filter passed
  genvar ga;
  generate
    for (ga = 0; ga < NUM_LANE; ga++) begin : g_pick_chk
      p_pick_is_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pick_ok[ga] |-> hit[pick_src[ga]]);
    end
  endgenerate

  // R3: with enough matches, every concentrator output slot is used
  p_fill_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cnt >= CNT_W'(NUM_LANE)) |-> (&pick_ok));

  // R6: at most one lane is read per cycle
  p_one_read_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lane_pop));

  // R8: the loss count never goes down
  p_loss_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loss_count >= $past(loss_count));

  // R9: output valid mirrors buffer occupancy before the previous edge
  p_valid_tracks_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(stored_any));

endmodule

// File: tb/koq_output_port_tb_top.sv
module koq_output_port_tb_top;

  localparam int N    = 8;
  localparam int L    = 4;
  localparam int D    = 8;
  localparam int AW   = 3;
  localparam int DW   = 16;
  localparam int LW   = 16;
  localparam int PID  = 3;
  localparam int CAP  = L * D;
  localparam int LMAX = (1 << LW) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      in_valid = '0;
  logic [N*AW-1:0]   in_dest = '0;
  logic [N*DW-1:0]   in_data = '0;
  logic              out_valid;
  logic [DW-1:0]     out_data;
  logic [LW-1:0]     loss_count;

  always #4 clk = ~clk;

  koq_output_port #(
    .NUM_IN(N), .NUM_LANE(L), .LANE_DEPTH(D), .ADDR_W(AW),
    .DATA_W(DW), .LOSS_W(LW), .PORT_ID(PID)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .loss_count(loss_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] q[$];
  int  offs = 0;
  int  exp_loss = 0;
  bit  exp_v = 0;
  logic [DW-1:0] exp_d = '0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: one shared queue of fixed capacity
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); offs = 0; exp_loss = 0; exp_v = 0;
    end else begin
      int pre, nm, acc, src;
      logic [DW-1:0] kept[$];
      pre = q.size();
      exp_v = (pre > 0);
      if (exp_v) exp_d = q.pop_front();
      nm = 0;
      kept.delete();
      for (int j = 0; j < N; j++) begin
        src = (offs + j) % N;
        if (in_valid[src] && in_dest[src*AW +: AW] == AW'(PID)) begin
          nm++;
          if (kept.size() < L) kept.push_back(in_data[src*DW +: DW]);
        end
      end
      acc = kept.size();
      if (acc > CAP - pre) acc = CAP - pre;
      for (int k = 0; k < acc; k++) q.push_back(kept[k]);
      exp_loss = exp_loss + nm - acc;
      if (exp_loss > LMAX) exp_loss = LMAX;
      offs = (offs + 1) % N;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(out_valid == exp_v, "R9 out_valid", int'(out_valid), int'(exp_v));
      if (exp_v && out_valid)
        check(out_data == exp_d, "R5 out_data order", int'(out_data), int'(exp_d));
      check(int'(loss_count) == exp_loss, "R3 loss_count", int'(loss_count), exp_loss);
    end
  end

  task automatic set_in(int i, bit v, bit match, logic [DW-1:0] d);
    in_valid[i]          = v;
    in_dest[i*AW +: AW]  = match ? AW'(PID) : AW'((PID + 1 + (i % (N - 1))) % N);
    in_data[i*DW +: DW]  = d;
  endtask

  task automatic clear_in();
    in_valid = '0; in_dest = '0; in_data = '0;
  endtask

  task automatic drain();
    clear_in();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int o, seen, loss0, tmp;
    logic [DW-1:0] want;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(loss_count == '0, "R1 loss in reset", int'(loss_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && loss_count == '0, "R1 first cycle", int'(out_valid), 0);

    // R6: single packet into an empty buffer, latency of two edges
    set_in(5, 1'b1, 1'b1, 16'h5A5A);
    @(negedge clk);
    clear_in();
    check(out_valid == 1'b0, "R6 not before edge t+1", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_data == 16'h5A5A, "R6 latency", int'(out_data), 16'h5A5A);
    drain();

    // R4: all inputs match once; first L in scan order from offset
    o = offs;
    for (int i = 0; i < N; i++) set_in(i, 1'b1, 1'b1, DW'(16'hA000 + i));
    @(negedge clk);
    clear_in();
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (out_valid && seen < L) begin
        want = DW'(16'hA000 + ((o + seen) % N));
        check(out_data == want, "R4 scan order", int'(out_data), int'(want));
        seen++;
      end
    end
    check(seen == L, "R4 kept count", seen, L);
    drain();

    // R2: only non-matching traffic, nothing stored and no loss
    loss0 = int'(loss_count);
    for (int c = 0; c < 40; c++) begin
      for (int i = 0; i < N; i++) set_in(i, 1'b1, 1'b0, DW'($urandom));
      @(negedge clk);
      check(out_valid == 1'b0, "R2 no output from foreign packets", int'(out_valid), 0);
    end
    clear_in();
    @(negedge clk);
    check(int'(loss_count) == loss0, "R2 loss unchanged", int'(loss_count), loss0);

    // mixed random traffic
    for (int c = 0; c < 600; c++) begin
      for (int i = 0; i < N; i++)
        set_in(i, ($urandom % 2) == 0, ($urandom % 3) == 0, DW'($urandom));
      @(negedge clk);
    end
    drain();

    // R7: sustained overload fills the lanes; full-lane drops add to concentrator drops
    loss0 = int'(loss_count);
    for (int c = 0; c < 20; c++) begin
      for (int i = 0; i < N; i++) set_in(i, 1'b1, 1'b1, DW'($urandom));
      @(negedge clk);
    end
    clear_in();
    tmp = int'(loss_count) - loss0;
    check(tmp > (N - L) * 20, "R7 full-lane drops", tmp, (N - L) * 20 + 1);
    check(int'(loss_count) == exp_loss, "R7 combined loss", int'(loss_count), exp_loss);
    drain();

    // R8: saturation of the loss counter
    for (int c = 0; c < 20000 && loss_count != {LW{1'b1}}; c++) begin
      for (int i = 0; i < N; i++) set_in(i, 1'b1, 1'b1, DW'($urandom));
      @(negedge clk);
    end
    check(loss_count == {LW{1'b1}}, "R8 reaches all ones", int'(loss_count), LMAX);
    repeat (10) @(negedge clk);
    check(loss_count == {LW{1'b1}}, "R8 stays saturated", int'(loss_count), LMAX);
    drain();

    finish_run();
  end

endmodule